// File: doc/BRIEF.md
# Stuck-at Fault Injecting Word Memory

This block is a 32-bit-wide synchronous single-port-per-direction RAM with a built-in fault injector. A fault experiment arms one permanent stuck-at fault on either the least significant bit (bit 0) or the most significant bit (bit 31) of one chosen word. While the fault is armed, every read of that word returns the stored data with the chosen bit forced to the stuck value. All other words and all other bits read back unchanged. Writes always reach the storage untouched.

The fault may only target addresses inside a used region that is fixed by parameters (`USED_LO` to `USED_HI`, both inclusive). A request for an address outside that region is refused and raises a sticky error. Each read that lands on the faulty word reports whether the injection was masked, meaning the stored bit already held the stuck value and the fault therefore changed nothing. An experiment uses this to separate injections with no effect from injections that really corrupt data.

Top module: `fi_mem_wrap`

## Requirements
- R1: A read request (`rd_en`=1) presents the 32-bit word of `rd_addr` on `rd_data` with `rd_valid`=1 exactly one clock later, whether or not a fault applies. A write (`wr_en`=1) stores `wr_data` at `wr_addr`. Without a read request, `rd_valid` is 0 the next cycle and `rd_data` holds its last value.
- R2: When a read and a write hit the same address in the same cycle, the read returns the value held before that write.
- R3: `cfg_set`=1 with `cfg_addr` in [`USED_LO`, `USED_HI`] arms the fault: `fault_active`=1 from the next cycle. The request also captures the target word, the target bit (`cfg_msb`=0 selects bit 0, `cfg_msb`=1 selects bit 31) and the polarity (`cfg_pol`=0 is stuck-at-0, `cfg_pol`=1 is stuck-at-1). The fault stays armed over any number of reads and writes until it is cleared or re-targeted.
- R4: A read of the target word while armed returns the stored word with the selected bit replaced by the polarity value, and `rd_hit`=1 alongside `rd_valid`.
- R5: Reads of any other address, and all non-selected bits of the target word, return the stored data unchanged, with `rd_hit`=0.
- R6: Writes to the target word update the storage normally. The fault keeps overriding the bit on later reads, and once the fault is cleared the true stored value reads back.
- R7: `rd_masked`=1 exactly when `rd_hit`=1 and the stored bit already equals the stuck value; otherwise it is 0.
- R8: `cfg_set`=1 with `cfg_addr` outside the used region sets `cfg_err`=1 and leaves `fault_active`=0 (any previous fault is disarmed). `cfg_err` stays set through later requests until `cfg_clear` or reset.
- R9: `cfg_clear`=1 drives both `fault_active` and `cfg_err` to 0 on the next cycle, and takes priority over a simultaneous `cfg_set`.
- R10: After reset, `fault_active`, `cfg_err`, `rd_valid`, `rd_hit`, `rd_masked` and `rd_data` are all 0.
- R11: A read uses the fault setting held before its request edge. A `cfg_set` or `cfg_clear` issued in the same cycle as a read affects only later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 32 | Read data, with the fault applied when the target word is read |
| rd_hit | output | 1 | The presented word was the armed target |
| rd_masked | output | 1 | The forced bit equalled the stored bit |
| cfg_set | input | 1 | Arm or re-target the fault |
| cfg_clear | input | 1 | Disarm the fault and clear the error |
| cfg_addr | input | ADDR_W | Target word address |
| cfg_msb | input | 1 | Target bit: 0 selects bit 0, 1 selects bit 31 |
| cfg_pol | input | 1 | Stuck value: 0 or 1 |
| fault_active | output | 1 | Fault armed |
| cfg_err | output | 1 | Sticky out-of-region request flag |

## Verification
The assertions check on every cycle:
- the one-cycle read timing and that `rd_data` holds between reads;
- the effect of arm, reject and clear requests on `fault_active` and `cfg_err`;
- that `cfg_err` stays set until cleared;
- that a masked or hit indication only appears when a fault was armed.

Only the bench scenarios can show the value-level behaviour: the forced bit, masking against the actual stored data, read-before-write ordering, the region boundaries, and same-cycle configuration ordering. They do so by comparing every output against a behavioural reference memory on every clock.

// File: rtl/fi_pkg.sv
package fi_pkg;

    localparam int WORD_W = 32;
    localparam int MSB_IDX = WORD_W - 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic { STUCK_LO = 1'b0, STUCK_HI = 1'b1 } stuck_e;
    typedef enum logic { TGT_LSB = 1'b0, TGT_MSB = 1'b1 } tgt_bit_e;

    typedef struct packed {
        logic     armed;
        tgt_bit_e sel;
        stuck_e   pol;
    } fault_cfg_t;

    typedef struct packed {
        logic     hit;
        tgt_bit_e sel;
        stuck_e   pol;
    } tap_ctl_t;

    function automatic int bit_index(tgt_bit_e sel);
        return (sel == TGT_MSB) ? MSB_IDX : 0;
    endfunction

    function automatic logic pick_bit(word_t w, tgt_bit_e sel);
        return (sel == TGT_MSB) ? w[MSB_IDX] : w[0];
    endfunction

    function automatic word_t force_bit(word_t w, tgt_bit_e sel, stuck_e pol);
        word_t r;
        r = w;
        if (sel == TGT_MSB) r[MSB_IDX] = logic'(pol);
        else                r[0]       = logic'(pol);
        return r;
    endfunction

    function automatic logic in_window(int a, int lo, int hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/fi_ram.sv
module fi_ram #(
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  fi_pkg::word_t       wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output fi_pkg::word_t       raw_q
);
    fi_pkg::word_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)        raw_q <= '0;
        else if (rd_en) raw_q <= store[rd_addr];
    end
endmodule

// File: rtl/fi_fault_ctl.sv
module fi_fault_ctl #(
    parameter int ADDR_W  = 6,
    parameter int USED_LO = 8,
    parameter int USED_HI = 47
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_set,
    input  logic                cfg_clear,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic                cfg_msb,
    input  logic                cfg_pol,
    output fi_pkg::fault_cfg_t  cfg_q,
    output logic [ADDR_W-1:0]   tgt_addr_q,
    output logic                err_q
);
    logic req_ok;
    assign req_ok = fi_pkg::in_window(int'(cfg_addr), USED_LO, USED_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '{armed: 1'b0, sel: fi_pkg::TGT_LSB, pol: fi_pkg::STUCK_LO};
            tgt_addr_q <= '0;
            err_q      <= 1'b0;
        end else if (cfg_clear) begin
            cfg_q.armed <= 1'b0;
            err_q       <= 1'b0;
        end else if (cfg_set) begin
            if (req_ok) begin
                cfg_q.armed <= 1'b1;
                cfg_q.sel   <= fi_pkg::tgt_bit_e'(cfg_msb);
                cfg_q.pol   <= fi_pkg::stuck_e'(cfg_pol);
                tgt_addr_q  <= cfg_addr;
            end else begin
                cfg_q.armed <= 1'b0;
                err_q       <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fi_read_tap.sv
module fi_read_tap #(
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  fi_pkg::fault_cfg_t  cfg_q,
    input  logic [ADDR_W-1:0]   tgt_addr_q,
    input  fi_pkg::word_t       raw_q,
    output logic                rd_valid,
    output fi_pkg::word_t       rd_data,
    output logic                rd_hit,
    output logic                rd_masked
);
    fi_pkg::tap_ctl_t ctl_q;
    logic             valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            ctl_q   <= '{hit: 1'b0, sel: fi_pkg::TGT_LSB, pol: fi_pkg::STUCK_LO};
        end else begin
            valid_q <= rd_en;
            if (rd_en) begin
                ctl_q.hit <= cfg_q.armed && (rd_addr == tgt_addr_q);
                ctl_q.sel <= cfg_q.sel;
                ctl_q.pol <= cfg_q.pol;
            end
        end
    end

    always_comb begin
        rd_valid  = valid_q;
        rd_data   = ctl_q.hit ? fi_pkg::force_bit(raw_q, ctl_q.sel, ctl_q.pol) : raw_q;
        rd_hit    = valid_q && ctl_q.hit;
        rd_masked = rd_hit && (fi_pkg::pick_bit(raw_q, ctl_q.sel) == logic'(ctl_q.pol));
    end
endmodule

// File: rtl/fi_mem_wrap.sv
module fi_mem_wrap #(
    parameter int ADDR_W  = 6,
    parameter int USED_LO = 8,
    parameter int USED_HI = 47
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [31:0]         wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic                rd_valid,
    output logic [31:0]         rd_data,
    output logic                rd_hit,
    output logic                rd_masked,
    input  logic                cfg_set,
    input  logic                cfg_clear,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic                cfg_msb,
    input  logic                cfg_pol,
    output logic                fault_active,
    output logic                cfg_err
);
    fi_pkg::word_t      raw_q;
    fi_pkg::fault_cfg_t cfg_q;
    logic [ADDR_W-1:0]  tgt_addr_q;

    fi_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .raw_q(raw_q)
    );

    fi_fault_ctl #(.ADDR_W(ADDR_W), .USED_LO(USED_LO), .USED_HI(USED_HI)) u_ctl (
        .clk(clk), .rst(rst),
        .cfg_set(cfg_set), .cfg_clear(cfg_clear), .cfg_addr(cfg_addr),
        .cfg_msb(cfg_msb), .cfg_pol(cfg_pol),
        .cfg_q(cfg_q), .tgt_addr_q(tgt_addr_q), .err_q(cfg_err)
    );

    fi_read_tap #(.ADDR_W(ADDR_W)) u_tap (
        .clk(clk), .rst(rst),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .cfg_q(cfg_q), .tgt_addr_q(tgt_addr_q), .raw_q(raw_q),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_hit(rd_hit), .rd_masked(rd_masked)
    );

    assign fault_active = cfg_q.armed;
endmodule

// File: rtl/fi_mem_wrap_chk.sv
module fi_mem_wrap_chk #(
    parameter int ADDR_W  = 6,
    parameter int USED_LO = 8,
    parameter int USED_HI = 47
) (
    input logic                clk,
    input logic                rst,
    input logic                rd_en,
    input logic                rd_valid,
    input logic [31:0]         rd_data,
    input logic                rd_hit,
    input logic                rd_masked,
    input logic                cfg_set,
    input logic                cfg_clear,
    input logic [ADDR_W-1:0]   cfg_addr,
    input logic                fault_active,
    input logic                cfg_err
);
    logic ok_req;
    assign ok_req = fi_pkg::in_window(int'(cfg_addr), USED_LO, USED_HI);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    a_r1_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);
    a_r1_data_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
    a_r3_arm: assert property (@(posedge clk) disable iff (rst)
        (cfg_set && !cfg_clear && ok_req) |=> fault_active);
    a_r3_persist: assert property (@(posedge clk) disable iff (rst)
        (!cfg_set && !cfg_clear) |=> $stable(fault_active));
    a_r8_reject: assert property (@(posedge clk) disable iff (rst)
        (cfg_set && !cfg_clear && !ok_req) |=> (!fault_active && cfg_err));
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && !cfg_clear) |=> cfg_err);
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        cfg_clear |=> (!fault_active && !cfg_err));
    a_r7_mask_needs_hit: assert property (@(posedge clk) disable iff (rst)
        rd_masked |-> rd_hit);
    a_r4_hit_needs_fault: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> ($past(fault_active) && rd_valid));
endmodule

bind fi_mem_wrap fi_mem_wrap_chk #(.ADDR_W(ADDR_W), .USED_LO(USED_LO), .USED_HI(USED_HI)) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_hit(rd_hit), .rd_masked(rd_masked), .cfg_set(cfg_set), .cfg_clear(cfg_clear),
    .cfg_addr(cfg_addr), .fault_active(fault_active), .cfg_err(cfg_err)
);

// File: tb/tb_fi_mem_wrap.sv
module tb_fi_mem_wrap;
    localparam int AW = 6;
    localparam int NW = 1 << AW;
    localparam int LO = 8;
    localparam int HI = 47;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          wr_en = 0, rd_en = 0, cfg_set = 0, cfg_clear = 0, cfg_msb = 0, cfg_pol = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0, cfg_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          rd_valid, rd_hit, rd_masked, fault_active, cfg_err;
    logic [31:0]   rd_data;

    fi_mem_wrap #(.ADDR_W(AW), .USED_LO(LO), .USED_HI(HI)) dut (.*);

    int total = 0;
    int bad = 0;

    // behavioural reference
    logic [31:0] m_mem [NW];
    logic        m_act = 0, m_err = 0, m_msb = 0, m_pol = 0;
    int          m_tgt = 0;
    logic        e_valid = 0, e_hit = 0, e_mask = 0;
    logic [31:0] e_data = 0;
    bit          model_on = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_err = 0; e_valid = 0; e_hit = 0; e_mask = 0; e_data = 0;
        end else begin
            if (rd_en) begin
                logic [31:0] w;
                int b;
                w = m_mem[rd_addr];
                b = m_msb ? 31 : 0;
                e_valid = 1;
                e_hit = m_act && (int'(rd_addr) == m_tgt);
                e_mask = e_hit && (w[b] == m_pol);
                if (e_hit) w[b] = m_pol;
                e_data = w;
            end else begin
                e_valid = 0; e_hit = 0; e_mask = 0;
            end
            if (wr_en) m_mem[wr_addr] = wr_data;
            if (cfg_clear) begin
                m_act = 0; m_err = 0;
            end else if (cfg_set) begin
                if (int'(cfg_addr) >= LO && int'(cfg_addr) <= HI) begin
                    m_act = 1; m_tgt = int'(cfg_addr); m_msb = cfg_msb; m_pol = cfg_pol;
                end else begin
                    m_act = 0; m_err = 1;
                end
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && !rst) begin
            chk("R1", 32'(rd_valid), 32'(e_valid), "rd_valid");
            chk(e_hit ? "R4" : "R5", rd_data, e_data, "rd_data");
            chk(e_hit ? "R4" : "R5", 32'(rd_hit), 32'(e_hit), "rd_hit");
            chk("R7", 32'(rd_masked), 32'(e_mask), "rd_masked");
            chk("R3", 32'(fault_active), 32'(m_act), "fault_active");
            chk("R8", 32'(cfg_err), 32'(m_err), "cfg_err");
        end
    end

    function automatic logic [31:0] pat(int a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
    endfunction

    // one cycle of stimulus; outputs reflect it when the task returns
    task automatic cyc(logic we, int wa, logic [31:0] wd, logic re, int ra,
                       logic cs, logic cc, int ca, logic cm, logic cp);
        wr_en = we; wr_addr = AW'(wa); wr_data = wd; rd_en = re; rd_addr = AW'(ra);
        cfg_set = cs; cfg_clear = cc; cfg_addr = AW'(ca); cfg_msb = cm; cfg_pol = cp;
        @(negedge clk);
        wr_en = 0; rd_en = 0; cfg_set = 0; cfg_clear = 0;
    endtask

    task automatic rd(int a);       cyc(0, 0, 0, 1, a, 0, 0, 0, 0, 0); endtask
    task automatic wr(int a, logic [31:0] d); cyc(1, a, d, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic arm(int a, logic m, logic p); cyc(0, 0, 0, 0, 0, 1, 0, a, m, p); endtask
    task automatic clr();           cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0); endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", {26'd0, rd_valid, rd_hit, rd_masked, fault_active, cfg_err, 1'b0}, 32'd0, "flags in reset");
        chk("R10", rd_data, 32'd0, "rd_data in reset");
        rst = 0;
        @(negedge clk);
        chk("R10", {27'd0, rd_valid, rd_hit, rd_masked, fault_active, cfg_err}, 32'd0, "flags after reset");
        model_on = 1;

        for (int a = 0; a < NW; a++) wr(a, pat(a));
        for (int a = 0; a < NW; a++) begin
            rd(a);
            chk("R1", rd_data, pat(a), "fill readback");
        end
        @(negedge clk);
        chk("R1", rd_data, pat(NW-1), "hold without read");

        // R2 read-before-write
        cyc(1, 20, 32'hDEAD_BEEF, 1, 20, 0, 0, 0, 0, 0);
        chk("R2", rd_data, pat(20), "same-cycle read old value");
        rd(20);
        chk("R2", rd_data, 32'hDEAD_BEEF, "new value after write");

        // R4/R7 all four bit/polarity combinations
        for (int k = 0; k < 4; k++) begin
            int a;
            logic m, p;
            logic [31:0] exp;
            a = 10 + k; m = k[1]; p = k[0];
            arm(a, m, p);
            rd(a);
            exp = pat(a);
            exp[m ? 31 : 0] = p;
            chk("R4", rd_data, exp, "forced word");
            chk("R7", 32'(rd_masked), 32'(pat(a)[m ? 31 : 0] == p), "masked flag");
            rd(a + 1);
            chk("R5", rd_data, pat(a + 1), "neighbour untouched");
        end

        // R6 write under fault: stuck-at-1 on bit 31 of word 30
        arm(30, 1, 1);
        wr(30, 32'h0000_0001);
        rd(30);
        chk("R6", rd_data, 32'h8000_0001, "fault overrides new data");
        chk("R7", 32'(rd_masked), 32'd0, "not masked when bit differs");
        wr(30, 32'h8000_0000);
        rd(30);
        chk("R7", 32'(rd_masked), 32'd1, "masked when bit equal");
        for (int i = 0; i < 5; i++) rd(30);
        chk("R3", 32'(rd_hit), 32'd1, "fault persists");
        wr(30, 32'h1234_5670);
        clr();
        rd(30);
        chk("R6", rd_data, 32'h1234_5670, "true value after clear");

        // R11 same-cycle config vs read
        arm(40, 0, 1);
        cyc(0, 0, 0, 1, 41, 1, 0, 41, 0, 1);
        chk("R11", 32'(rd_hit), 32'd0, "read uses old target");
        rd(41);
        chk("R11", 32'(rd_hit), 32'd1, "new target on next read");

        // R8 region boundaries and stickiness
        arm(LO, 0, 0);
        chk("R8", {30'd0, fault_active, cfg_err}, 32'b10, "low edge accepted");
        arm(HI, 1, 0);
        chk("R8", {30'd0, fault_active, cfg_err}, 32'b10, "high edge accepted");
        arm(LO - 1, 0, 0);
        chk("R8", {30'd0, fault_active, cfg_err}, 32'b01, "below region rejected");
        rd(HI);
        chk("R8", 32'(rd_hit), 32'd0, "rejected request disarms");
        arm(HI + 1, 0, 1);
        chk("R8", 32'(cfg_err), 32'd1, "above region rejected");
        arm(25, 0, 1);
        chk("R8", {30'd0, fault_active, cfg_err}, 32'b11, "error sticky across good arm");

        // R9 clear wins over set
        cyc(0, 0, 0, 0, 0, 1, 1, 26, 1, 1);
        chk("R9", {30'd0, fault_active, cfg_err}, 32'b00, "clear priority");

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            cyc($urandom_range(0, 1) == 1, $urandom_range(0, NW-1), $urandom,
                $urandom_range(0, 2) != 0, (r < 50) ? $urandom_range(LO, LO+3) : $urandom_range(0, NW-1),
                r < 6, r == 99, (r < 4) ? $urandom_range(LO, LO+3) : $urandom_range(0, NW-1),
                $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
        end

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule